// File: doc/BRIEF.md
# Fault-Tolerant Bridge Gate Sequencer

This block produces the four bridge gate drives and the boost-switch drive for an isolated full-bridge converter that has an extra boost switch behind its rectifier. While healthy, the two legs run at 50% duty each. The second leg is delayed against the first by a phase command, which sets the output voltage. The boost switch stays off. Every pair of complementary switches in a leg is separated by a programmable dead time.

A fault code from an external short-circuit detector names the shorted switch. On that code the sequencer forces every output low at once. It holds them low for a minimum lock interval, which always ends on a period boundary. It then restarts as an asymmetrical half-bridge. Both gates of the faulted leg stay off. The other leg runs a fixed 50% complementary pattern, still with dead time. The boost switch is pulse-width modulated at twice the bridge frequency from a duty command. A code that names no single switch leaves the block locked until reset.

Top module: `bridge_gate_seq`

## Requirements
- R1: During reset and in the first cycle after it, `gates` is 4'b0000 and `boostGate` is 0.
- R2: In normal mode the period is PERIOD cycles. The leg A high-side request covers the first PERIOD/2 counts. The leg B requests follow the same pattern delayed by the latched phase. Each of the four gates is high for PERIOD/2 − DEAD cycles per period, and the rising edge of `gates[2]` lags that of `gates[0]` by exactly the phase value in cycles.
- R3: The two gates of one leg (bits 0/1 = leg A high/low, bits 2/3 = leg B high/low) are never high together. At every hand-over both are low for exactly DEAD cycles, so each leg spends 2·DEAD cycles per period with both gates off.
- R4: `boostGate` stays low for as long as no fault code has been accepted.
- R5: `phaseCmd` and `boostDuty` are captured only in the last cycle of a period. A change made within a period has no effect until the next period.
- R6: A phase command above PERIOD/2 acts as PERIOD/2.
- R7: A nonzero `faultCode` seen in normal mode drives all gates and `boostGate` low from the next cycle. The lock lasts at least LOCK_CYC cycles and ends on a period boundary.
- R8: The fault code names the shorted switch: 1 = leg A high, 2 = leg A low, 3 = leg B high, 4 = leg B low. After codes 1 and 2 both leg A gates stay low, and after codes 3 and 4 both leg B gates stay low.
- R9: After reconfiguration the healthy leg runs a complementary pattern aligned to the period start. Each of its gates is high for PERIOD/2 − DEAD cycles per period, whatever the phase command is.
- R10: After reconfiguration `boostGate` is high for the first D cycles of each half period, where D is the latched `boostDuty` clamped to PERIOD/2 − 1. This gives two pulses per bridge period.
- R11: Fault codes 5 to 7 keep every gate and `boostGate` low until reset.
- R12: Once a fault has been accepted, later fault codes have no effect until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseCmd | input | $clog2(PERIOD) | Leg B delay in cycles, normal mode |
| boostDuty | input | $clog2(PERIOD) | Boost on-time per half period, in cycles |
| faultCode | input | 3 | Shorted switch code, 0 = none |
| gates | output | 4 | Bridge gates: [0] A high, [1] A low, [2] B high, [3] B low |
| boostGate | output | 1 | Boost switch gate |

## Verification
The assertions check on every cycle the properties that need no knowledge of the period position. These are leg exclusivity, a low cycle after each falling gate, the boost staying off before a fault, the immediate lock, the faulted leg staying dark, and the permanent lock on invalid codes. Only the bench scenarios can show pulse widths, phase lag, the exact dead-time totals and the period-aligned command capture. The same holds for lock length, healthy-leg duty and the doubled boost frequency, which the bench measures over whole periods aligned to a gate edge.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_LOCK, ST_AHB, ST_HALT} seqState_t;

  typedef struct packed {
    logic kill;       // force every drive low
    logic ahb;        // half-bridge pattern active
    logic legBFault;  // faulted leg is leg B
    logic sample;     // capture commands this cycle
  } seqCtl_t;
endpackage

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
  import bgs_pkg::*;
#(
  parameter int LOCK_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] faultCode,
  input  logic       periodEnd,
  output seqCtl_t    ctl
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  seqState_t      state;
  logic [2:0]     codeQ;
  logic [LW-1:0]  lockCnt;
  logic           lockDone, codeValid;

  assign lockDone  = lockCnt >= LW'(LOCK_CYC - 1);
  assign codeValid = (codeQ >= 3'd1) && (codeQ <= 3'd4);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      codeQ   <= '0;
      lockCnt <= '0;
    end else begin
      case (state)
        ST_RUN: if (faultCode != 3'd0) begin
          state   <= ST_LOCK;
          codeQ   <= faultCode;
          lockCnt <= '0;
        end
        ST_LOCK: begin
          if (lockCnt != LW'(LOCK_CYC)) lockCnt <= lockCnt + 1'b1;
          if (lockDone && periodEnd) state <= codeValid ? ST_AHB : ST_HALT;
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    ctl.kill      = (state == ST_RUN && faultCode != 3'd0) ||
                    state == ST_LOCK || state == ST_HALT;
    ctl.ahb       = (state == ST_AHB);
    ctl.legBFault = (codeQ == 3'd3) || (codeQ == 3'd4);
    ctl.sample    = periodEnd;
  end
endmodule

// File: rtl/bgs_deadtime.sv
module bgs_deadtime #(
  parameter int DEAD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] req,   // [0] high side, [1] low side
  output logic [1:0] gate
);
  localparam int DW = $clog2(DEAD + 2);

  logic [1:0]    prevReq;
  logic [DW-1:0] holdCnt, nextCnt;

  always_comb begin
    if (req != prevReq)                nextCnt = DW'(1);
    else if (holdCnt == DW'(DEAD + 1)) nextCnt = holdCnt;
    else                               nextCnt = holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevReq <= '0;
      holdCnt <= DW'(DEAD + 1);
      gate    <= '0;
    end else begin
      prevReq <= req;
      holdCnt <= nextCnt;
      gate    <= (nextCnt <= DW'(DEAD)) ? 2'b00 : req;
    end
  end
endmodule

// File: rtl/bgs_datapath.sv
module bgs_datapath
  import bgs_pkg::*;
#(
  parameter int PERIOD = 100,
  parameter int DEAD   = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqCtl_t                   ctl,
  input  logic [$clog2(PERIOD)-1:0] phaseCmd,
  input  logic [$clog2(PERIOD)-1:0] boostDuty,
  output logic                      periodEnd,
  output logic [3:0]                gates,
  output logic                      boostGate
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] HALF    = CW'(PERIOD / 2);
  localparam logic [CW-1:0] DUTYMAX = CW'(PERIOD / 2 - 1);

  logic [CW-1:0] cnt, phQ, dutyQ, cntH;
  logic [CW:0]   shifted;
  logic          refHigh, bHigh;
  logic [1:0]    legReq [2];
  logic [1:0]    legGate [2];

  assign periodEnd = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      phQ   <= '0;
      dutyQ <= '0;
    end else begin
      cnt <= periodEnd ? '0 : cnt + 1'b1;
      if (ctl.sample) begin
        phQ   <= (phaseCmd > HALF) ? HALF : phaseCmd;
        dutyQ <= (boostDuty > DUTYMAX) ? DUTYMAX : boostDuty;
      end
    end
  end

  always_comb begin
    refHigh = cnt < HALF;
    if (cnt >= phQ) shifted = {1'b0, cnt} - {1'b0, phQ};
    else            shifted = {1'b0, cnt} + (CW+1)'(PERIOD) - {1'b0, phQ};
    bHigh = shifted < {1'b0, HALF};
    cntH  = refHigh ? cnt : cnt - HALF;

    if (ctl.kill) begin
      legReq[0] = 2'b00;
      legReq[1] = 2'b00;
    end else if (ctl.ahb) begin
      legReq[0] = ctl.legBFault ? {~refHigh, refHigh} : 2'b00;
      legReq[1] = ctl.legBFault ? 2'b00 : {~refHigh, refHigh};
    end else begin
      legReq[0] = {~refHigh, refHigh};
      legReq[1] = {~bHigh, bHigh};
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    bgs_deadtime #(.DEAD(DEAD)) i_dt (
      .clk (clk),
      .rstN(rstN),
      .req (legReq[g]),
      .gate(legGate[g])
    );
    assign gates[2*g +: 2] = legGate[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) boostGate <= 1'b0;
    else       boostGate <= !ctl.kill && ctl.ahb && (cntH < dutyQ);
  end
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bgs_pkg::*;
#(
  parameter int PERIOD   = 100,
  parameter int DEAD     = 4,
  parameter int LOCK_CYC = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [$clog2(PERIOD)-1:0] phaseCmd,
  input  logic [$clog2(PERIOD)-1:0] boostDuty,
  input  logic [2:0]                faultCode,
  output logic [3:0]                gates,
  output logic                      boostGate
);
  seqCtl_t ctl;
  logic    periodEnd;

  bgs_ctrl #(.LOCK_CYC(LOCK_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .faultCode(faultCode),
    .periodEnd(periodEnd), .ctl(ctl)
  );

  bgs_datapath #(.PERIOD(PERIOD), .DEAD(DEAD)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phaseCmd(phaseCmd),
    .boostDuty(boostDuty), .periodEnd(periodEnd),
    .gates(gates), .boostGate(boostGate)
  );
endmodule

// File: rtl/bgs_chk.sv
module bgs_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] faultCode,
  input logic [3:0] gates,
  input logic       boostGate
);
  logic       faultSeen;
  logic [2:0] firstCode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultSeen <= 1'b0;
      firstCode <= '0;
    end else if (!faultSeen && faultCode != 3'd0) begin
      faultSeen <= 1'b1;
      firstCode <= faultCode;
    end
  end

  p_leg_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(gates[0] && gates[1]) && !(gates[2] && gates[3]));

  p_gap_a_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gates[0]) |=> !gates[1]) and ($fell(gates[1]) |=> !gates[0]));

  p_gap_b_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gates[2]) |=> !gates[3]) and ($fell(gates[3]) |=> !gates[2]));

  p_boost_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !faultSeen |-> !boostGate);

  p_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!faultSeen && faultCode != 3'd0) |=> (gates == 4'b0000 && !boostGate));

  p_leg_dark_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultSeen |-> (((firstCode == 3'd1 || firstCode == 3'd2) -> gates[1:0] == 2'b00) &&
                   ((firstCode == 3'd3 || firstCode == 3'd4) -> gates[3:2] == 2'b00)));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    (faultSeen && firstCode > 3'd4) |-> (gates == 4'b0000 && !boostGate));
endmodule

bind bridge_gate_seq bgs_chk i_chk (
  .clk(clk), .rstN(rstN), .faultCode(faultCode),
  .gates(gates), .boostGate(boostGate)
);

// File: tb/test_bridge_gate_seq.sv
module test_bridge_gate_seq;
  localparam int P = 40;
  localparam int D = 3;
  localparam int L = 10;
  localparam int W = $clog2(P);
  localparam int H = P / 2;

  // phase command, boost duty, expected leg B lag
  localparam int VEC [5][3] = '{'{0, 5, 0}, '{7, 10, 7}, '{20, 3, 20},
                                '{35, 8, 20}, '{13, 0, 13}};

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] phaseCmd = '0, boostDuty = '0;
  logic [2:0] faultCode = '0;
  logic [3:0] gates;
  logic boostGate;

  int errs = 0, checks = 0;
  int onCnt [4];
  int bOn, bRise, riseOff, gapA, gapB;
  logic [3:0] prevG;
  logic prevB;

  always #2 clk = ~clk;

  bridge_gate_seq #(.PERIOD(P), .DEAD(D), .LOCK_CYC(L)) i_bridge_gate_seq (
    .clk(clk), .rstN(rstN), .phaseCmd(phaseCmd), .boostDuty(boostDuty),
    .faultCode(faultCode), .gates(gates), .boostGate(boostGate)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int syncIdx, input int newPh);
    prevG = gates;
    prevB = boostGate;
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (gates[syncIdx] && !prevG[syncIdx]) break;
      prevG = gates;
      prevB = boostGate;
    end
    if (newPh >= 0) phaseCmd = W'(newPh);
    for (int j = 0; j < 4; j++) onCnt[j] = 0;
    bOn = 0; bRise = 0; riseOff = -1; gapA = 0; gapB = 0;
    for (int k = 0; k < P; k++) begin
      if (k > 0) @(negedge clk);
      for (int j = 0; j < 4; j++) if (gates[j]) onCnt[j]++;
      if (boostGate) bOn++;
      if (boostGate && !prevB) bRise++;
      if (gates[2] && !prevG[2] && riseOff < 0) riseOff = k;
      if (gates[1:0] == 2'b00) gapA++;
      if (gates[3:2] == 2'b00) gapB++;
      prevG = gates;
      prevB = boostGate;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; faultCode = '0;
    waitCyc(4);
    chk("R1 gates in reset", int'(gates), 0);
    chk("R1 boost in reset", int'(boostGate), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 gates after reset", int'(gates), 0);
  endtask

  initial begin
    #(4 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    doReset();

    // R2 R3 R4 R6: normal phase-shift patterns
    for (int v = 0; v < 5; v++) begin
      phaseCmd = W'(VEC[v][0]);
      boostDuty = W'(VEC[v][1]);
      waitCyc(P + 2);
      measure(0, -1);
      for (int j = 0; j < 4; j++) chk("R2 gate width", onCnt[j], H - D);
      chk(VEC[v][0] > H ? "R6 clamped lag" : "R2 leg B lag", riseOff, VEC[v][2]);
      chk("R3 leg A dead total", gapA, 2 * D);
      chk("R3 leg B dead total", gapB, 2 * D);
      chk("R4 boost idle", bOn, 0);
    end

    // R5: mid-period change waits for the boundary
    phaseCmd = W'(7);
    waitCyc(P + 2);
    measure(0, 15);
    chk("R5 old phase kept", riseOff, 7);
    measure(0, -1);
    chk("R5 new phase applied", riseOff, 15);

    // R7 R8 R9 R10: fault on leg B low side
    boostDuty = W'(6);
    waitCyc(P + 2);
    faultCode = 3'd4;
    @(negedge clk);
    faultCode = 3'd0;
    chk("R7 gates locked", int'(gates), 0);
    chk("R7 boost locked", int'(boostGate), 0);
    n = 1;
    while (gates == 4'b0000 && n < 3 * P) begin @(negedge clk); n++; end
    chk("R7 lock length", int'(n >= L), 1);
    waitCyc(P);
    measure(0, -1);
    chk("R9 healthy high", onCnt[0], H - D);
    chk("R9 healthy low", onCnt[1], H - D);
    chk("R8 faulted high", onCnt[2], 0);
    chk("R8 faulted low", onCnt[3], 0);
    chk("R10 boost on-time", bOn, 12);
    chk("R10 boost pulses", bRise, 2);
    boostDuty = W'(30);
    phaseCmd = W'(3);
    waitCyc(P + 2);
    measure(0, -1);
    chk("R10 boost clamp", bOn, 2 * (H - 1));
    chk("R10 clamp pulses", bRise, 2);
    chk("R9 phase ignored", onCnt[0], H - D);
    faultCode = 3'd1;
    @(negedge clk);
    faultCode = 3'd0;
    waitCyc(P);
    measure(0, -1);
    chk("R12 later code ignored A", onCnt[0], H - D);
    chk("R12 later code ignored B", onCnt[2], 0);

    // R8 R9: fault on leg A high side
    doReset();
    boostDuty = W'(4);
    waitCyc(P + 2);
    faultCode = 3'd1;
    @(negedge clk);
    faultCode = 3'd0;
    waitCyc(L + 2 * P);
    measure(2, -1);
    chk("R8 leg A dark high", onCnt[0], 0);
    chk("R8 leg A dark low", onCnt[1], 0);
    chk("R9 leg B high", onCnt[2], H - D);
    chk("R9 leg B low", onCnt[3], H - D);
    chk("R10 boost leg B case", bOn, 8);

    // R11: invalid code holds lock
    doReset();
    waitCyc(P);
    faultCode = 3'd6;
    @(negedge clk);
    faultCode = 3'd0;
    waitCyc(3 * P);
    n = 0;
    for (int k = 0; k < 2 * P; k++) begin
      @(negedge clk);
      if (gates != 4'b0000 || boostGate) n++;
    end
    chk("R11 locked cycles active", n, 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule